// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block turns a fixed functional clock into the two timing strobes that a UART's shift logic runs on. A programmable 16-bit divisor N sets the sample rate: one `sample_tick` pulse every N clocks. A mode input picks the oversampling ratio, 16 or 13 samples per bit. A `bit_tick` pulse marks the last sample of each bit. The baud rate is therefore clk/(16·N) or clk/(13·N). The 13x ratio lets a fixed clock reach rates that 16x cannot hit closely. With a 48 MHz clock, 13x with N=8 gives 460,800 baud, and 13x with N=1 gives about 3.69 Mbaud. The 16x ratio gives 9600 baud with N=312 and 115,200 baud with N=26.

The divisor and mode in use are shadow copies of the inputs. While the generator is running, the shadow is refreshed only on the cycle that carries a bit tick, so no bit is ever cut short or stretched. While the generator is stopped, because the enable is low or the divisor in use is zero, the shadow follows the inputs on every clock. The divider and the bit-phase counter are held at their start values during that time.

Top module: `baud_tick_gen`

## Requirements
- R1: During reset and on the first clock after reset is released, both ticks are low. Reset clears the divisor in use to zero.
- R2: While running with divisor in use N, `sample_tick` is a one-clock pulse on every Nth clock. With N=1 it is high on every running clock.
- R3: With `os13`=0 (16x), `bit_tick` fires on every 16th sample tick, giving a bit period of 16·N clocks.
- R4: With `os13`=1 (13x), `bit_tick` fires on every 13th sample tick, giving a bit period of 13·N clocks.
- R5: `bit_tick` is only ever high together with `sample_tick`.
- R6: A divisor change made during a bit has no effect until the clock after the next bit tick. The current bit keeps its old length and the next bit uses the new one.
- R7: A mode change made during a bit takes effect in the same way, only after the next bit tick.
- R8: A divisor in use of zero stops both ticks. After a non-zero divisor is applied, the first sample tick comes on the second clock after the input changes when N=2, and in general on the Nth running clock.
- R9: While `en` is low, both ticks stay low and the phase restarts. After `en` rises, the first sample tick comes on the Nth clock with `en` high and the first bit tick on clock 16·N or 13·N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the generator idle |
| divisor | input | 16 | Clocks per sample tick; 0 stops the generator |
| os13 | input | 1 | Oversampling select: 0 = 16x, 1 = 13x |
| sample_tick | output | 1 | One-clock strobe per oversample |
| bit_tick | output | 1 | One-clock strobe on the last sample of each bit |

## Verification
The two events that share a cycle are the bit-boundary tick and the reload of the shadow divisor and mode. On that clock the divider must restart from the new input value, not the old one. The bench provokes this by changing the divisor and the mode one clock after a bit tick. It then measures two consecutive bit intervals, expecting the old length and then the new one. A behavioural model in the bench judges every clock, including changes made on the boundary cycle itself and a divisor of zero applied at a boundary.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic {
    OS_X16 = 1'b0,
    OS_X13 = 1'b1
  } os_mode_e;

  // Final phase index for a given mode: ratio minus one.
  function automatic int unsigned phase_last(input logic mode,
                                             input int unsigned ratio_lo,
                                             input int unsigned ratio_hi);
    return (mode == OS_X13) ? (ratio_hi - 1) : (ratio_lo - 1);
  endfunction

endpackage

// File: rtl/baud_cfg_shadow.sv
module baud_cfg_shadow #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             mode_in,
  output logic [DIV_W-1:0] div_q,
  output logic             mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      div_q  <= div_in;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] reload_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || tick)
      cnt_q <= reload_val;
    else
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/baud_phase_cnt.sv
module baud_phase_cnt #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            step,
  input  logic [PH_W-1:0] last,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);
  assign wrap = step && (phase == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      phase <= '0;
    else if (step)
      phase <= wrap ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W    = 16,
  parameter int RATIO_LO = 16,
  parameter int RATIO_HI = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  input  logic             os13,
  output logic             sample_tick,
  output logic             bit_tick
);
  import baud_pkg::*;

  localparam int RATIO_MAX = (RATIO_LO > RATIO_HI) ? RATIO_LO : RATIO_HI;
  localparam int PH_W      = (RATIO_MAX > 1) ? $clog2(RATIO_MAX) : 1;

  // Count start value for a divisor; zero maps to zero, the stop state handles it.
  function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  // Named internal events (also observed by the checker)
  logic [DIV_W-1:0] act_div;
  logic             act_mode;
  logic             act_zero;
  logic             run;
  logic             cfg_load;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  phase_lim;
  logic [DIV_W-1:0] reload_val;
  logic             smp;
  logic             wrap;

  assign act_zero   = (act_div == '0);
  assign run        = en && !act_zero;
  assign cfg_load   = !run || wrap;
  assign reload_val = cfg_load ? reload_of(divisor) : reload_of(act_div);
  assign phase_lim  = PH_W'(phase_last(act_mode, RATIO_LO, RATIO_HI));

  baud_cfg_shadow #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .div_in(divisor), .mode_in(os13),
    .div_q(act_div), .mode_q(act_mode)
  );

  baud_div_cnt #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run),
    .reload_val(reload_val), .tick(smp)
  );

  baud_phase_cnt #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .step(smp),
    .last(phase_lim), .phase(phase), .wrap(wrap)
  );

  assign sample_tick = smp;
  assign bit_tick    = wrap;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W    = 16,
  parameter int PH_W     = 4,
  parameter int RATIO_LO = 16,
  parameter int RATIO_HI = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sample_tick,
  input logic             bit_tick,
  input logic             run,
  input logic             act_zero,
  input logic [DIV_W-1:0] act_div,
  input logic             act_mode,
  input logic [PH_W-1:0]  phase
);
  import baud_pkg::*;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sample_tick && !bit_tick));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !bit_tick && act_div > 1) |=> !sample_tick);

  // R3 / R4: phase never passes the last index of the mode in use
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(phase) <= phase_last(act_mode, RATIO_LO, RATIO_HI)));

  a_r5_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R6 and R7: shadow config holds between bit boundaries
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_tick) |=> ($stable(act_div) && $stable(act_mode)));

  a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    act_zero |-> (!sample_tick && !bit_tick));

  a_r9_disable_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sample_tick && !bit_tick));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .DIV_W(DIV_W), .PH_W(PH_W), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .sample_tick(sample_tick), .bit_tick(bit_tick),
  .run(run), .act_zero(act_zero), .act_div(act_div),
  .act_mode(act_mode), .phase(phase)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic        os13 = 1'b0;
  logic        sample_tick, bit_tick;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor), .os13(os13),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  // Behavioural reference: the rate settings in use, a countdown to the next sample, and a sample index.
  int m_n = 0, m_mode = 0, m_left = 0, m_idx = 0;

  function automatic int spb(input int mode);
    return mode ? 13 : 16;
  endfunction

  function automatic bit m_active();
    return en && (m_n != 0);
  endfunction

  function automatic bit m_smp();
    return m_active() && (m_left == 0);
  endfunction

  function automatic bit m_bit();
    return m_smp() && (m_idx == spb(m_mode) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_mode = 0; m_left = 0; m_idx = 0;
    end else if (!m_active() || m_bit()) begin
      m_n = divisor; m_mode = os13;
      m_left = (divisor == 0) ? 0 : divisor - 1;
      m_idx = 0;
    end else if (m_smp()) begin
      m_left = m_n - 1;
      m_idx++;
    end else begin
      m_left--;
    end
  end

  // Every-cycle comparison (R2, R3, R4, R5 via the model)
  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      tests++;
      if (sample_tick !== m_smp() || bit_tick !== m_bit()) begin
        fails++;
        $display("FAIL R2/R3/R4 model: sample=%b bit=%b expected sample=%b bit=%b",
                 sample_tick, bit_tick, m_smp(), m_bit());
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #3;
  endtask

  // Clocks from now until the next bit tick (inclusive).
  task automatic to_bit(output int n, output bit smp_with);
    n = 0;
    do begin step(); n++; end while (!bit_tick && n < 5000);
    smp_with = sample_tick;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, cnt;
    bit sw;
    // R1: reset
    divisor = 16'd3;
    en = 1'b1;
    repeat (3) step();
    check("R1 ticks in reset", sample_tick + bit_tick, 0);
    rst_n = 1'b1;
    step();
    check("R1 first cycle after reset", sample_tick + bit_tick, 0);

    // R2 / R3: N=3, 16x
    to_bit(n, sw);
    to_bit(n, sw);
    check("R3 bit period 16x N=3", n, 48);
    check("R5 bit tick with sample", sw, 1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); cnt += sample_tick; end
    check("R2 samples in 30 clocks N=3", cnt, 10);

    // R4: 13x, N=4
    step(); divisor = 16'd4; os13 = 1'b1;
    to_bit(n, sw);
    to_bit(n, sw);
    check("R4 bit period 13x N=4", n, 52);
    to_bit(n, sw);
    check("R4 second bit 13x N=4", n, 52);

    // R2 N=1: sample every clock, 16x
    step(); divisor = 16'd1; os13 = 1'b0;
    to_bit(n, sw);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin step(); cnt += sample_tick; end
    check("R2 N=1 samples in 10 clocks", cnt, 10);
    to_bit(n, sw);
    to_bit(n, sw);
    check("R3 bit period 16x N=1", n, 16);

    // R6: divisor change mid-bit
    step(); divisor = 16'd5;
    to_bit(n, sw);
    step(); divisor = 16'd2;
    to_bit(n, sw);
    check("R6 old divisor kept for current bit", n + 1, 80);
    to_bit(n, sw);
    check("R6 new divisor after boundary", n, 32);

    // R7: mode change mid-bit
    step(); os13 = 1'b1;
    to_bit(n, sw);
    check("R7 old mode kept for current bit", n + 1, 32);
    to_bit(n, sw);
    check("R7 new mode after boundary", n, 26);

    // Boundary-cycle change: change lands on the bit-tick cycle itself
    to_bit(n, sw);
    divisor = 16'd3; os13 = 1'b0;
    to_bit(n, sw);
    check("R6 change on boundary cycle applies at once", n, 48);

    // R8: zero divisor applied at a boundary
    divisor = 16'd0;
    to_bit(n, sw);
    step();
    cnt = 0;
    for (int i = 0; i < 100; i++) begin step(); cnt += sample_tick + bit_tick; end
    check("R8 no ticks with N=0", cnt, 0);
    divisor = 16'd2;
    step();
    check("R8 no tick one clock after resume", sample_tick, 0);
    step();
    check("R8 first tick two clocks after resume", sample_tick, 1);

    // R9: enable low then high, 13x N=3
    step(); en = 1'b0; divisor = 16'd3; os13 = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt += sample_tick + bit_tick; end
    check("R9 no ticks while disabled", cnt, 0);
    en = 1'b1;
    n = 1; cnt = 0;
    while (!sample_tick && n < 100) begin step(); n++; end
    check("R9 first sample on 3rd enabled clock", n, 3);
    while (!bit_tick && n < 200) begin step(); n++; end
    check("R9 first bit on 39th enabled clock", n, 39);

    repeat (5) step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule